// File: doc/BRIEF.md
# Conditional relative branch unit

This unit sits in the fetch and decode path of a small 8-bit controller core whose program memory holds 16-bit instruction words and whose program counter addresses bytes. It recognises the two "branch when a status flag is clear" instructions, tests the flag each one names, and forms a PC-relative target from a signed 8-bit offset counted in words. The offset is sign-extended, doubled and added to the address that follows the branch. When the branch falls through, the sequential address is passed on and nothing else changes.

Every instruction cycle is made of four clock phases, driven in from outside: decode, literal read, process and PC write. The unit latches the decoded opcode and the PC in the decode phase and the offset in the literal phase. It samples the flags and forms the target in the process phase, and it presents the next PC during the write phase. A taken branch raises a one-clock flush strobe in the write phase. The whole instruction cycle that follows is then marked as a bubble: the prefetched word runs as a no-op and cannot itself start a branch. Taken branches therefore cost two instruction cycles and fall-through branches one. The unit never writes a status flag.

Top module: `cond_branch_unit`

## Requirements
- R1: An instruction whose upper byte is 0xE3 is a branch that tests the carry flag, and one whose upper byte is 0xE7 is a branch that tests the negative flag; `is_branch_o` is high during phases 1, 2 and 3 of such a cycle and low in phase 0.
- R2: A branch is taken when its own flag is 0, whatever value the other flag has.
- R3: A taken branch at address P with low byte n presents next PC = (P + 2 + 2·n) modulo 2^PC_W, with n read as two's complement (-128 to 127), during phase 3.
- R4: A branch whose tested flag is 1 presents next PC = (P + 2) modulo 2^PC_W during phase 3 and raises no flush.
- R5: `flush_o` is high for exactly one clock, in phase 3 of a taken branch cycle, and is low at every other time.
- R6: The instruction cycle after a taken branch is a bubble: `bubble_o` is high in all four of its phases, its word is never treated as a branch, no flush is raised, and its next PC is its own address plus 2.
- R7: A word whose upper byte is neither 0xE3 nor 0xE7 leaves `is_branch_o` and `flush_o` low and presents next PC = P + 2.
- R8: While reset (active low, asynchronous) is applied and after its release, `flush_o`, `is_branch_o` and `bubble_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one edge per quarter cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Current phase: 0 decode, 1 literal, 2 process, 3 PC write |
| instr_i | input | 16 | Instruction word being executed, held for the whole cycle |
| pc_i | input | PC_W (21) | Byte address of that instruction |
| carry_i | input | 1 | Carry status flag |
| neg_i | input | 1 | Negative status flag |
| next_pc_o | output | PC_W (21) | Next PC to be loaded, valid in phase 3 |
| flush_o | output | 1 | One-clock strobe in phase 3 that discards the prefetched word |
| is_branch_o | output | 1 | A conditional branch has been decoded in this cycle |
| bubble_o | output | 1 | The current cycle is the forced no-op after a taken branch |

## Verification
The embedded assertions watch every clock for the sequencing rules: a flush only in the write phase and never on two clocks in a row, a bubble that starts only after a taken branch and lasts through the next write phase, no decode or flush during a bubble, and a target whose lowest bit matches the sequential address. The arithmetic of the target, including wrap-around at both ends of the address space, which flag each opcode tests, and which upper bytes count as branches can only be shown by the bench. It runs directed instruction cycles and compares each phase-3 result with a reference computed from the requirements.

// File: rtl/brn_pkg.sv
package brn_pkg;

    // Phase numbering within one instruction cycle; the order is behaviour.
    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_LITERAL = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;

    localparam int INSTR_W = 16;
    localparam int OFF_W   = 8;
    localparam int OPC_W   = INSTR_W - OFF_W;

    // Upper-byte opcodes of the two flag-clear branches.
    localparam logic [OPC_W-1:0] OPC_CARRY_CLR = 8'hE3;
    localparam logic [OPC_W-1:0] OPC_NEG_CLR   = 8'hE7;

    // Bit of the opcode that tells the two apart.
    localparam int SEL_BIT = 2;

endpackage

// File: rtl/brn_decode.sv
module brn_decode
    import brn_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output logic             hit_o,
    output logic             use_neg_o
);

    logic match_c;
    logic match_n;

    always_comb begin
        match_c   = (opc_i == OPC_CARRY_CLR);
        match_n   = (opc_i == OPC_NEG_CLR);
        hit_o     = match_c | match_n;
        use_neg_o = opc_i[SEL_BIT];
    end

    // R1 R7
    always_comb begin
        dec_prefix_chk: assert (!hit_o || (opc_i[7:4] == 4'hE && opc_i[1:0] == 2'b11))
            else $error("decode hit on a word outside the branch pattern");
    end

endmodule

// File: rtl/brn_target.sv
module brn_target
    import brn_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [PC_W-1:0]  base_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  target_o
);

    localparam int EXT_W = PC_W - OFF_W - 1;

    logic [PC_W-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
        target_o = base_i + disp;
    end

    // R3
    always_comb begin
        tgt_parity_chk: assert (target_o[0] == base_i[0])
            else $error("target parity differs from sequential address");
    end

endmodule

// File: rtl/brn_seq.sv
module brn_seq
    import brn_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       phase_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             hit_i,
    input  logic             use_neg_i,
    input  logic             carry_i,
    input  logic             neg_i,
    input  logic [PC_W-1:0]  target_i,
    output logic [PC_W-1:0]  base_o,
    output logic [OFF_W-1:0] off_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             flush_o,
    output logic             is_branch_o,
    output logic             bubble_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    typedef struct packed {
        logic             dec;
        logic             use_neg;
        logic [PC_W-1:0]  base;
        logic [OFF_W-1:0] off;
        logic             taken;
        logic [PC_W-1:0]  target;
        logic             bubble;
    } st_t;

    st_t st_d, st_q;
    logic flag_sel;

    always_comb begin
        st_d     = st_q;
        flag_sel = st_q.use_neg ? neg_i : carry_i;
        case (phase_e'(phase_i))
            PH_DECODE: begin
                st_d.dec     = hit_i & ~st_q.bubble;
                st_d.use_neg = use_neg_i;
                st_d.base    = pc_i + STEP;
            end
            PH_LITERAL: begin
                st_d.off = off_i;
            end
            PH_PROCESS: begin
                st_d.taken  = st_q.dec & ~flag_sel;
                st_d.target = target_i;
            end
            PH_WRITE: begin
                st_d.bubble = st_q.taken;
                st_d.taken  = 1'b0;
                st_d.dec    = 1'b0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        base_o      = st_q.base;
        off_o       = st_q.off;
        next_pc_o   = st_q.taken ? st_q.target : st_q.base;
        flush_o     = st_q.taken;
        is_branch_o = st_q.dec;
        bubble_o    = st_q.bubble;
    end

    // R5
    flush_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (phase_e'(phase_i) == PH_WRITE));

    // R5
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R6
    bubble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bubble_o) |-> $past(flush_o));

    // R6
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble_o && phase_e'(phase_i) != PH_WRITE) |=> bubble_o);

    // R6
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> (!is_branch_o && !flush_o));

    // R6
    flush_then_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> bubble_o);

    // R1
    decode_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_e'(phase_i) == PH_DECODE) |-> !is_branch_o);

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import brn_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         phase_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               carry_i,
    input  logic               neg_i,
    output logic [PC_W-1:0]    next_pc_o,
    output logic               flush_o,
    output logic               is_branch_o,
    output logic               bubble_o
);

    logic             hit;
    logic             use_neg;
    logic [PC_W-1:0]  base;
    logic [OFF_W-1:0] off;
    logic [PC_W-1:0]  target;

    brn_decode i_decode (
        .opc_i     (instr_i[INSTR_W-1:OFF_W]),
        .hit_o     (hit),
        .use_neg_o (use_neg)
    );

    brn_target #(.PC_W(PC_W)) i_target (
        .base_i   (base),
        .off_i    (off),
        .target_o (target)
    );

    brn_seq #(.PC_W(PC_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase_i),
        .pc_i        (pc_i),
        .off_i       (instr_i[OFF_W-1:0]),
        .hit_i       (hit),
        .use_neg_i   (use_neg),
        .carry_i     (carry_i),
        .neg_i       (neg_i),
        .target_i    (target),
        .base_o      (base),
        .off_o       (off),
        .next_pc_o   (next_pc_o),
        .flush_o     (flush_o),
        .is_branch_o (is_branch_o),
        .bubble_o    (bubble_o)
    );

endmodule

// File: tb/test_cond_branch_unit.sv
`timescale 1ns/1ps
module test_cond_branch_unit;

    localparam int PC_W = 21;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      phase = 2'd0;
    logic [15:0]     instr = 16'h0000;
    logic [PC_W-1:0] pc = '0;
    logic            carry = 1'b0;
    logic            neg = 1'b0;
    logic [PC_W-1:0] next_pc;
    logic            flush;
    logic            is_branch;
    logic            bubble;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  running = 1'b0;
    bit  done = 1'b0;
    bit  exp_bubble = 1'b0;

    typedef struct {
        logic [PC_W-1:0] npc;
        logic            fl;
        logic            br;
        logic            bub;
        string           tag;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    cond_branch_unit #(.PC_W(PC_W)) i_cond_branch_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .instr_i     (instr),
        .pc_i        (pc),
        .carry_i     (carry),
        .neg_i       (neg),
        .next_pc_o   (next_pc),
        .flush_o     (flush),
        .is_branch_o (is_branch),
        .bubble_o    (bubble)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: computes the expected result from the requirements and runs one cycle.
    task automatic run_cycle(input logic [15:0] ins, input logic [PC_W-1:0] p,
                             input logic c, input logic n, input string tag);
        item_t it;
        logic  hit;
        logic  tk;
        logic [PC_W-1:0] disp;
        hit  = !exp_bubble && (ins[15:8] == 8'hE3 || ins[15:8] == 8'hE7);
        tk   = hit && ((ins[15:8] == 8'hE3) ? !c : !n);
        disp = {{(PC_W-9){ins[7]}}, ins[7:0], 1'b0};
        it.npc = tk ? (p + PC_W'(2) + disp) : (p + PC_W'(2));
        it.fl  = tk;
        it.br  = hit;
        it.bub = exp_bubble;
        it.tag = tag;
        sb.push_back(it);
        exp_bubble = tk;
        for (int ph = 0; ph < 4; ph++) begin
            phase = ph[1:0];
            instr = ins;
            pc    = p;
            carry = c;
            neg   = n;
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compares at mid-clock, pops the item in phase 3.
    always @(negedge clk) begin
        if (running && rst_n) begin
            if (phase == 2'd3) begin
                if (sb.size() == 0) begin
                    chk("R5 scoreboard underflow", 32'd0, 32'd1);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.tag, 32'(next_pc), 32'(it.npc));
                    chk("R5 flush in phase 3", 32'(flush), 32'(it.fl));
                    chk(it.br ? "R1 is_branch" : "R7 is_branch", 32'(is_branch), 32'(it.br));
                    chk("R6 bubble", 32'(bubble), 32'(it.bub));
                end
            end else begin
                chk("R5 flush outside phase 3", 32'(flush), 32'd0);
                if (phase == 2'd0) begin
                    chk("R1 is_branch in phase 0", 32'(is_branch), 32'd0);
                end else if (sb.size() != 0) begin
                    chk("R1 is_branch in phases 1-2", 32'(is_branch), 32'(sb[0].br));
                    chk("R6 bubble held", 32'(bubble), 32'(sb[0].bub));
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: outputs during reset
        chk("R8 flush in reset", 32'(flush), 32'd0);
        chk("R8 is_branch in reset", 32'(is_branch), 32'd0);
        chk("R8 bubble in reset", 32'(bubble), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 flush after reset", 32'(flush), 32'd0);
        chk("R8 is_branch after reset", 32'(is_branch), 32'd0);
        chk("R8 bubble after reset", 32'(bubble), 32'd0);
        phase = 2'd3;
        @(posedge clk);
        #1;
        running = 1'b1;

        // R2: carry branch taken with negative flag set
        run_cycle(16'hE310, 21'h000100, 1'b0, 1'b1, "R2 taken, other flag set");
        // R6: branch word during the bubble is ignored
        run_cycle(16'hE305, 21'h000102, 1'b0, 1'b0, "R6 bubble next_pc");
        // R4: tested flag set
        run_cycle(16'hE310, 21'h000122, 1'b1, 1'b0, "R4 carry set");
        // R3: most negative offset, negative-flag branch
        run_cycle(16'hE780, 21'h000400, 1'b1, 1'b0, "R3 offset -128");
        run_cycle(16'h0F00, 21'h000302, 1'b0, 1'b0, "R6 bubble next_pc");
        // R4: negative flag set
        run_cycle(16'hE77F, 21'h001000, 1'b0, 1'b1, "R4 negative set");
        // R3: largest positive offset
        run_cycle(16'hE77F, 21'h001000, 1'b0, 1'b0, "R3 offset 127");
        run_cycle(16'h1234, 21'h001100, 1'b1, 1'b1, "R6 bubble next_pc");
        // R7: neighbouring opcodes are not branches
        run_cycle(16'hE210, 21'h002000, 1'b0, 1'b0, "R7 opcode E2");
        run_cycle(16'hE6FF, 21'h002002, 1'b0, 1'b0, "R7 opcode E6");
        run_cycle(16'hF300, 21'h002004, 1'b0, 1'b0, "R7 opcode F3");
        // R3: wrap past the top of the address space
        run_cycle(16'hE305, 21'h1FFFFE, 1'b0, 1'b1, "R3 wrap top");
        run_cycle(16'hE700, 21'h00000A, 1'b0, 1'b0, "R6 bubble next_pc");
        // R3: wrap below zero
        run_cycle(16'hE780, 21'h000000, 1'b1, 1'b0, "R3 wrap bottom");
        run_cycle(16'h0000, 21'h1FFF02, 1'b0, 1'b0, "R6 bubble next_pc");
        // R4: sequential wrap
        run_cycle(16'hE301, 21'h1FFFFE, 1'b1, 1'b0, "R4 sequential wrap");
        // back-to-back fall-through then taken, zero offset
        run_cycle(16'hE700, 21'h000200, 1'b1, 1'b1, "R4 back to back");
        run_cycle(16'hE700, 21'h000202, 1'b1, 1'b0, "R3 zero offset");
        run_cycle(16'h0000, 21'h000204, 1'b0, 1'b0, "R6 bubble next_pc");

        running = 1'b0;
        chk("R5 scoreboard drained", 32'(sb.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule